// File: doc/BRIEF.md
# I2C Operating Mode Control Register

This block is the mode and control register of an I2C bus controller. A CPU writes and reads one 8-bit control word through a plain register port. The word holds a module enable, a bit that can stall the next reception, the master and transmit selects, and a 4-bit transfer clock select. The block also listens to event strobes from the bus engine and changes the mode bits itself when the bus requires it.

The block has four outputs besides the read data: the current operating mode, a bus-drive enable, a flag that holds off the next reception, and a pair of signals that time the data setup interval before the controller drives SDA in slave transmit mode. The shift engine, START/STOP generation and SCL rate division are outside this block and use these outputs.

Top module: `i2c_mode_ctl`

## Requirements
- R1: After reset the control word reads 0x00. The mode output is 00, and bus-drive enable, hold, setup busy and setup done are all 0.
- R2: A write cycle loads the whole control word on the next clock edge and it reads back at once. Bit 7 is enable, bit 6 is receive-stall, bit 5 is master select, bit 4 is transmit select and bits 3:0 are clock select. With no write and no mode event the word stays unchanged.
- R3: The mode output is {master, transmit}: 00 slave receive, 01 slave transmit, 10 master receive, 11 master transmit.
- R4: Bus-drive enable equals the enable bit.
- R5: While enabled, an arbitration-lost strobe in a master mode clears the master and transmit bits at the next edge, which gives slave receive. In a slave mode the strobe has no effect.
- R6: While enabled in slave receive, an address-match strobe with R/W bit 1 sets the transmit bit, which gives slave transmit. A match with R/W bit 0 changes nothing.
- R7: When a CPU write and an R5 or R6 update fall in the same cycle, the master and transmit bits take the hardware value and the other bits take the written value.
- R8: The hold output sets one cycle after a receive-data read strobe seen while enabled with receive-stall 1 and transmit 0. It then stays set. A read with receive-stall 0 or transmit 1 leaves it clear.
- R9: A write that clears receive-stall clears the hold output at the next edge.
- R10: While enabled in slave transmit, an SCL-low strobe loads the setup counter with 10 when clock select bit 3 is 0. Setup busy rises on the next edge, and setup done pulses on the 10th edge after the loading edge. An SCL-low strobe in any other mode starts nothing.
- R11: With clock select bit 3 set to 1 the load is 20, and done pulses on the 20th edge after loading. Busy is high while the count is non-zero. Done lasts exactly one cycle.
- R12: Clearing the enable bit clears the setup counter and the hold flag at the same edge and keeps the other written bits. While disabled, arbitration, address-match and SCL-low strobes have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr_en | input | 1 | CPU write strobe for the control word |
| reg_wdata | input | 8 | CPU write data |
| reg_rdata | output | 8 | Current control word |
| arb_lost | input | 1 | Bus engine: arbitration lost strobe |
| addr_match | input | 1 | Bus engine: own slave address matched |
| addr_rw | input | 1 | R/W bit that came with the address match |
| rx_data_rd | input | 1 | Receive data register read strobe |
| scl_fall | input | 1 | Bus engine: SCL driven/seen low strobe |
| mode_o | output | 2 | Operating mode {master, transmit} |
| bus_drive_en | output | 1 | SCL/SDA drivers enabled |
| rx_hold | output | 1 | Next reception is held off |
| setup_busy | output | 1 | Slave transmit setup interval running |
| setup_done | output | 1 | One-cycle pulse at end of setup interval |

## Verification
The hardest cases to reach are the collisions where a CPU write and a hardware mode update land in the same cycle. To reach them, the stimulus first puts the word in master receive or slave receive with a write. It then drives a write carrying conflicting mode bits together with the arbitration or address strobe, and checks that only the mode field resists the write. The halt case is reached by starting the setup interval and writing enable low halfway through the count. The bench then confirms at the ports that busy drops and that no done pulse appears later.

// File: rtl/i2c_mode_pkg.sv
package i2c_mode_pkg;

    localparam int CLK_SEL_W = 4;

    typedef enum logic [1:0] {
        MODE_SLV_RX = 2'b00,
        MODE_SLV_TX = 2'b01,
        MODE_MST_RX = 2'b10,
        MODE_MST_TX = 2'b11
    } i2c_mode_e;

    // Packed MSB first: the field order is the software-visible layout.
    typedef struct packed {
        logic                 en;
        logic                 rx_stall;
        logic                 mst;
        logic                 trs;
        logic [CLK_SEL_W-1:0] clk_sel;
    } ctl_word_t;

    localparam int CTL_W = $bits(ctl_word_t);

endpackage

// File: rtl/i2c_ctl_reg.sv
module i2c_ctl_reg
    import i2c_mode_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [CTL_W-1:0] wdata,
    input  logic             arb_lost,
    input  logic             addr_match,
    input  logic             addr_rw,
    output ctl_word_t        ctl_q,
    output logic             halt_req
);

    ctl_word_t ctl_d;
    ctl_word_t wr_word;

    assign wr_word  = ctl_word_t'(wdata);
    assign halt_req = wr_en && !wr_word.en;

    always_comb begin
        ctl_d = ctl_q;
        if (wr_en) begin
            ctl_d = wr_word;
        end
        // Hardware mode updates act on the current mode and override the write.
        if (ctl_q.en) begin
            if (arb_lost && ctl_q.mst) begin
                ctl_d.mst = 1'b0;
                ctl_d.trs = 1'b0;
            end else if (addr_match && addr_rw && !ctl_q.mst && !ctl_q.trs) begin
                ctl_d.mst = 1'b0;
                ctl_d.trs = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q <= '0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

endmodule

// File: rtl/i2c_rx_hold.sv
module i2c_rx_hold (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic rx_stall,
    input  logic trs,
    input  logic rd_strobe,
    input  logic wr_en,
    input  logic wr_en_bit,
    input  logic wr_stall_bit,
    output logic hold_q
);

    logic hold_d;
    logic clr;
    logic set;

    always_comb begin
        clr    = !en || (wr_en && (!wr_en_bit || !wr_stall_bit));
        set    = en && rd_strobe && rx_stall && !trs;
        hold_d = hold_q;
        if (clr) begin
            hold_d = 1'b0;
        end else if (set) begin
            hold_d = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_q <= 1'b0;
        end else begin
            hold_q <= hold_d;
        end
    end

endmodule

// File: rtl/i2c_setup_timer.sv
module i2c_setup_timer #(
    parameter int SETUP_SHORT = 10,
    parameter int SETUP_LONG  = 20
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic halt,
    input  logic start,
    input  logic long_sel,
    output logic busy,
    output logic done
);

    localparam int CNT_W = $clog2(SETUP_LONG + 1);
    localparam logic [CNT_W-1:0] LOAD_SHORT = CNT_W'(SETUP_SHORT);
    localparam logic [CNT_W-1:0] LOAD_LONG  = CNT_W'(SETUP_LONG);
    localparam logic [CNT_W-1:0] CNT_ONE    = CNT_W'(1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             done;
    } tmr_t;

    tmr_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        if (start) begin
            st_d.cnt = long_sel ? LOAD_LONG : LOAD_SHORT;
        end else if (st_q.cnt != '0) begin
            st_d.cnt  = st_q.cnt - CNT_ONE;
            st_d.done = (st_q.cnt == CNT_ONE);
        end
        if (!en || halt) begin
            st_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign busy = (st_q.cnt != '0);
    assign done = st_q.done;

endmodule

// File: rtl/i2c_mode_ctl.sv
module i2c_mode_ctl
    import i2c_mode_pkg::*;
#(
    parameter int SETUP_SHORT = 10,
    parameter int SETUP_LONG  = 20
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       reg_wr_en,
    input  logic [7:0] reg_wdata,
    output logic [7:0] reg_rdata,
    input  logic       arb_lost,
    input  logic       addr_match,
    input  logic       addr_rw,
    input  logic       rx_data_rd,
    input  logic       scl_fall,
    output logic [1:0] mode_o,
    output logic       bus_drive_en,
    output logic       rx_hold,
    output logic       setup_busy,
    output logic       setup_done
);

    ctl_word_t ctl_q;
    ctl_word_t wr_word;
    logic      halt_req;
    i2c_mode_e mode;
    logic      tmr_start;

    assign wr_word = ctl_word_t'(reg_wdata);

    i2c_ctl_reg u_reg (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (reg_wr_en),
        .wdata     (reg_wdata),
        .arb_lost  (arb_lost),
        .addr_match(addr_match),
        .addr_rw   (addr_rw),
        .ctl_q     (ctl_q),
        .halt_req  (halt_req)
    );

    assign mode      = i2c_mode_e'({ctl_q.mst, ctl_q.trs});
    assign tmr_start = ctl_q.en && scl_fall && (mode == MODE_SLV_TX);

    i2c_rx_hold u_hold (
        .clk         (clk),
        .rst_n       (rst_n),
        .en          (ctl_q.en),
        .rx_stall    (ctl_q.rx_stall),
        .trs         (ctl_q.trs),
        .rd_strobe   (rx_data_rd),
        .wr_en       (reg_wr_en),
        .wr_en_bit   (wr_word.en),
        .wr_stall_bit(wr_word.rx_stall),
        .hold_q      (rx_hold)
    );

    i2c_setup_timer #(
        .SETUP_SHORT(SETUP_SHORT),
        .SETUP_LONG (SETUP_LONG)
    ) u_tmr (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (ctl_q.en),
        .halt    (halt_req),
        .start   (tmr_start),
        .long_sel(ctl_q.clk_sel[CLK_SEL_W-1]),
        .busy    (setup_busy),
        .done    (setup_done)
    );

    assign reg_rdata    = ctl_q;
    assign mode_o       = mode;
    assign bus_drive_en = ctl_q.en;

endmodule

// File: rtl/i2c_mode_ctl_chk.sv
module i2c_mode_ctl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       reg_wr_en,
    input logic [7:0] reg_rdata,
    input logic       arb_lost,
    input logic       addr_match,
    input logic       addr_rw,
    input logic       rx_data_rd,
    input logic [1:0] mode_o,
    input logic       bus_drive_en,
    input logic       rx_hold,
    input logic       setup_busy,
    input logic       setup_done
);

    assert_quiet_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!reg_wr_en && !arb_lost && !addr_match) |=> $stable(reg_rdata));

    assert_arb_to_slave_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_drive_en && arb_lost && mode_o[1]) |=> (mode_o == 2'b00));

    assert_match_to_tx_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_drive_en && addr_match && addr_rw && mode_o == 2'b00) |=> (mode_o == 2'b01));

    assert_hold_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_drive_en && rx_data_rd && reg_rdata[6] && !reg_rdata[4] && !reg_wr_en) |=> rx_hold);

    assert_done_after_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(setup_done) |-> $past(setup_busy));

    assert_done_single_R11: assert property (@(posedge clk) disable iff (!rst_n)
        setup_done |=> !setup_done);

    assert_halt_clean_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_drive_en |-> (!rx_hold && !setup_busy && !setup_done));

endmodule

bind i2c_mode_ctl i2c_mode_ctl_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .reg_wr_en   (reg_wr_en),
    .reg_rdata   (reg_rdata),
    .arb_lost    (arb_lost),
    .addr_match  (addr_match),
    .addr_rw     (addr_rw),
    .rx_data_rd  (rx_data_rd),
    .mode_o      (mode_o),
    .bus_drive_en(bus_drive_en),
    .rx_hold     (rx_hold),
    .setup_busy  (setup_busy),
    .setup_done  (setup_done)
);

// File: tb/sim_i2c_mode_ctl.sv
module sim_i2c_mode_ctl;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_wr_en = 1'b0;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic       arb_lost = 1'b0;
    logic       addr_match = 1'b0;
    logic       addr_rw = 1'b0;
    logic       rx_data_rd = 1'b0;
    logic       scl_fall = 1'b0;
    logic [1:0] mode_o;
    logic       bus_drive_en;
    logic       rx_hold;
    logic       setup_busy;
    logic       setup_done;

    always #4 clk = ~clk;

    i2c_mode_ctl u0 (
        .clk         (clk),
        .rst_n       (rst_n),
        .reg_wr_en   (reg_wr_en),
        .reg_wdata   (reg_wdata),
        .reg_rdata   (reg_rdata),
        .arb_lost    (arb_lost),
        .addr_match  (addr_match),
        .addr_rw     (addr_rw),
        .rx_data_rd  (rx_data_rd),
        .scl_fall    (scl_fall),
        .mode_o      (mode_o),
        .bus_drive_en(bus_drive_en),
        .rx_hold     (rx_hold),
        .setup_busy  (setup_busy),
        .setup_done  (setup_done)
    );

    localparam int S_RDATA = 0;
    localparam int S_MODE  = 1;
    localparam int S_BUS   = 2;
    localparam int S_HOLD  = 3;
    localparam int S_BUSY  = 4;
    localparam int S_DONE  = 5;

    typedef struct {
        int    due;
        int    sel;
        int    val;
        string tag;
    } exp_t;

    exp_t q[$];
    int   cyc = 0;
    int   n_cmp = 0;
    int   n_bad = 0;
    bit   finished = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;

    function automatic int actual(int sel);
        case (sel)
            S_RDATA: return int'(reg_rdata);
            S_MODE:  return int'(mode_o);
            S_BUS:   return int'(bus_drive_en);
            S_HOLD:  return int'(rx_hold);
            S_BUSY:  return int'(setup_busy);
            default: return int'(setup_done);
        endcase
    endfunction

    // Monitor: compares every queued item whose cycle has come.
    always @(negedge clk) begin
        for (int i = q.size() - 1; i >= 0; i--) begin
            if (q[i].due == cyc) begin
                n_cmp++;
                if (actual(q[i].sel) != q[i].val) begin
                    n_bad++;
                    $display("FAIL %s sel=%0d actual=0x%0h expected=0x%0h cyc=%0d",
                             q[i].tag, q[i].sel, actual(q[i].sel), q[i].val, cyc);
                end
                q.delete(i);
            end
        end
    end

    task automatic exp_at(int d, int sel, int val, string tag);
        exp_t e;
        e.due = cyc + d;
        e.sel = sel;
        e.val = val;
        e.tag = tag;
        q.push_back(e);
    endtask

    task automatic expn(int sel, int val, string tag);
        exp_at(1, sel, val, tag);
    endtask

    task automatic tick();
        @(negedge clk);
        reg_wr_en  = 1'b0;
        arb_lost   = 1'b0;
        addr_match = 1'b0;
        addr_rw    = 1'b0;
        rx_data_rd = 1'b0;
        scl_fall   = 1'b0;
    endtask

    task automatic idle(int n);
        repeat (n) tick();
    endtask

    task automatic wr(logic [7:0] v);
        reg_wr_en = 1'b1;
        reg_wdata = v;
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog actual=timeout expected=completion");
            summary();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        expn(S_RDATA, 0, "R1"); expn(S_MODE, 0, "R1"); expn(S_BUS, 0, "R1");
        expn(S_HOLD, 0, "R1"); expn(S_BUSY, 0, "R1"); expn(S_DONE, 0, "R1");
        tick();

        // R2/R3/R4 write and readback: master transmit
        wr(8'hB5);
        expn(S_RDATA, 8'hB5, "R2"); expn(S_MODE, 3, "R3"); expn(S_BUS, 1, "R4");
        tick();
        // R5 arbitration lost in master transmit
        arb_lost = 1'b1;
        expn(S_MODE, 0, "R5"); expn(S_RDATA, 8'h85, "R5");
        tick();
        // R7 write colliding with arbitration loss
        wr(8'hA0); expn(S_MODE, 2, "R3"); tick();
        wr(8'hF0); arb_lost = 1'b1; expn(S_RDATA, 8'hC0, "R7"); tick();
        // R5 arbitration lost in slave transmit: ignored
        wr(8'hD0); expn(S_MODE, 1, "R3"); tick();
        arb_lost = 1'b1; expn(S_RDATA, 8'hD0, "R5"); tick();

        // R8/R9 hold flag
        wr(8'hC0); tick();
        rx_data_rd = 1'b1; expn(S_HOLD, 1, "R8"); tick();
        expn(S_HOLD, 1, "R8"); tick();
        wr(8'h80); expn(S_HOLD, 0, "R9"); tick();
        rx_data_rd = 1'b1; expn(S_HOLD, 0, "R8"); tick();
        wr(8'hD0); tick();
        rx_data_rd = 1'b1; expn(S_HOLD, 0, "R8"); tick();

        // R6 address match
        wr(8'h80); tick();
        addr_match = 1'b1; addr_rw = 1'b0; expn(S_RDATA, 8'h80, "R6"); tick();
        addr_match = 1'b1; addr_rw = 1'b1;
        expn(S_MODE, 1, "R6"); expn(S_RDATA, 8'h90, "R6"); tick();
        // R7 write colliding with address match
        wr(8'h80); tick();
        wr(8'hA0); addr_match = 1'b1; addr_rw = 1'b1; expn(S_RDATA, 8'h90, "R7"); tick();

        // R10 short setup interval (slave transmit, clk_sel bit 3 = 0)
        scl_fall = 1'b1;
        exp_at(1, S_BUSY, 1, "R10"); exp_at(10, S_DONE, 0, "R10");
        exp_at(11, S_DONE, 1, "R10"); exp_at(11, S_BUSY, 0, "R11");
        exp_at(12, S_DONE, 0, "R11");
        tick(); idle(13);

        // R11 long setup interval
        wr(8'h98); tick();
        scl_fall = 1'b1;
        exp_at(20, S_BUSY, 1, "R11"); exp_at(20, S_DONE, 0, "R11");
        exp_at(21, S_DONE, 1, "R11"); exp_at(22, S_DONE, 0, "R11");
        tick(); idle(23);

        // R12 halt mid-count
        scl_fall = 1'b1; tick(); idle(5);
        wr(8'h18);
        expn(S_BUSY, 0, "R12"); expn(S_BUS, 0, "R12"); expn(S_RDATA, 8'h18, "R12");
        exp_at(15, S_DONE, 0, "R12");
        tick(); idle(20);
        // R12 halt clears hold
        wr(8'hC0); tick();
        rx_data_rd = 1'b1; tick();
        wr(8'h40); expn(S_HOLD, 0, "R12"); expn(S_RDATA, 8'h40, "R12"); tick();
        // R12 events ignored while disabled
        wr(8'h20); tick();
        arb_lost = 1'b1; expn(S_RDATA, 8'h20, "R12"); tick();
        wr(8'h00); tick();
        addr_match = 1'b1; addr_rw = 1'b1; expn(S_RDATA, 8'h00, "R12"); tick();
        wr(8'h10); tick();
        scl_fall = 1'b1; expn(S_BUSY, 0, "R12"); tick();
        // R10 SCL-low in master mode starts nothing
        wr(8'hB0); tick();
        scl_fall = 1'b1; expn(S_BUSY, 0, "R10"); tick();

        idle(4);
        if (q.size() != 0) begin
            n_bad++;
            $display("FAIL pending actual=%0d expected=0", q.size());
        end
        finished = 1'b1;
        summary();
    end

endmodule